// File: doc/BRIEF.md
# Deferred-Read Pulse Edge Timestamper

This block timestamps the rising edge of a once-per-second pulse against a free-running time base, without asking the host to react at the moment of the edge. Two up-counters advance together at one quarter of the core clock. The first never stops and acts as the time base. The second is the elapsed counter. It is cleared to zero on each qualified rising edge of the pulse and then counts up, so it always holds the time since the last edge.

The host may poll late. It raises a snapshot strobe, and the block then latches four things in one clock cycle: the synchronised pulse level, both counters and a stale flag. From that snapshot it presents a timestamp, which is the time base minus the elapsed count in modular arithmetic. It also presents a new-edge flag, which says whether the latched level rose since the previous snapshot. A falling edge yields no timestamp.

The elapsed counter stops at its maximum value and does not wrap. When that happens the stale flag marks the reading as unusable. An echo output copies the synchronised level, either true or inverted, and is meant only for visual indication.

Top module: `pps_stamp_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `snap_timebase`, `snap_elapsed`, `snap_level`, `snap_new_edge`, `snap_stale`, `stamp` and `echo_out` are all zero.
- R2: While `enable` is high, the time base advances by exactly one every DIV clock cycles (default DIV=4) and wraps modulo 2^CNT_W (default CNT_W=16).
- R3: A synchronised rising edge of `pps_in` with `enable` high clears the elapsed counter to zero. The counter then advances at the same tick as the time base. Before the first edge it holds zero.
- R4: `pps_in` passes through a two-flop synchroniser. The level seen by the snapshot and by the echo changes on the second rising clock edge after the input changes.
- R5: A falling edge of `pps_in` does not clear or disturb the elapsed counter, so the timestamp stays unchanged.
- R6: The elapsed counter saturates at 2^CNT_W-1. On reaching that value it sets the stale flag, and the next qualified rising edge clears the flag.
- R7: One cycle with `snap_req` high latches the level, the time base, the elapsed count and the stale flag from the same clock edge. The snapshot outputs hold those values until the next request.
- R8: `stamp` equals `snap_timebase - snap_elapsed` modulo 2^CNT_W. Between two edges, and before saturation, it is the same for every snapshot. It lies within one tick of the time base at the edge.
- R9: `snap_new_edge` is set by a snapshot whose latched level is 1 when the previous snapshot's level was 0. Otherwise it is cleared, including when the level has fallen.
- R10: With `echo_en` low, `echo_out` is 0. With `echo_en` high, `echo_out` equals the synchronised level XOR `echo_invert`.
- R11: While `enable` is low, both counters and the prescaler hold their values, and rising edges do not clear the elapsed counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the prescaler and both counters |
| pps_in | input | 1 | Asynchronous pulse input |
| echo_en | input | 1 | Drive the echo output |
| echo_invert | input | 1 | Invert the echo polarity |
| snap_req | input | 1 | Latch a coherent snapshot this cycle |
| snap_level | output | 1 | Latched synchronised pulse level |
| snap_new_edge | output | 1 | Latched level rose since the previous snapshot |
| snap_timebase | output | CNT_W | Latched time base |
| snap_elapsed | output | CNT_W | Latched elapsed-since-edge count |
| snap_stale | output | 1 | Latched saturation flag |
| stamp | output | CNT_W | Reconstructed edge time |
| echo_out | output | 1 | Echo of the synchronised level |

## Verification
The assertions assume that the pulse input is either quiet or changes at most once every few cycles. Under that assumption a synchronised rise lasts only one cycle, and the counters tick only on prescaler boundaries. They also assume `snap_req` is driven synchronously. The bench meets both assumptions. It changes `pps_in` and `snap_req` only at the falling clock edge, and it keeps every pulse level for several tick periods. It uses an 8-bit counter width so that wrap and saturation are reached within the run.

// File: rtl/pps_stamp_pkg.sv
package pps_stamp_pkg;

    localparam int DEF_CNT_W = 16;
    localparam int DEF_DIV   = 4;

    typedef enum logic [1:0] {
        ECHO_OFF  = 2'd0,
        ECHO_TRUE = 2'd1,
        ECHO_INV  = 2'd2
    } echo_mode_e;

    function automatic echo_mode_e echo_mode(input logic en, input logic inv);
        if (!en)
            return ECHO_OFF;
        return inv ? ECHO_INV : ECHO_TRUE;
    endfunction

    function automatic logic echo_drive(input echo_mode_e mode, input logic level);
        case (mode)
            ECHO_TRUE: return level;
            ECHO_INV:  return ~level;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pps_sync_edge.sv
module pps_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise
);
    logic s1, s2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            prev <= 1'b0;
        end else begin
            s1   <= din;
            s2   <= s1;
            prev <= s2;
        end
    end

    assign level = s2;
    assign rise  = s2 & ~prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst) rise |=> !rise); // R4
    AST_LEVEL_LAG: assert property (@(posedge clk) disable iff (rst) $rose(level) |-> $past(s1)); // R4

endmodule

// File: rtl/pps_prescaler.sv
module pps_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic tick
);
    localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst)
            pre <= '0;
        else if (enable)
            pre <= (pre == LAST) ? '0 : pre + 1'b1;
    end

    assign tick = enable && (pre == LAST);

    generate
        if (DIV > 1) begin : g_gap
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst) tick |=> !tick); // R2
        end
    endgenerate
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst) !enable |=> $stable(pre)); // R11

endmodule

// File: rtl/pps_counters.sv
module pps_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic             rise,
    output logic [CNT_W-1:0] timebase,
    output logic [CNT_W-1:0] elapsed,
    output logic             stale
);
    localparam logic [CNT_W-1:0] MAXV = '1;
    localparam logic [CNT_W-1:0] NEAR = MAXV - 1'b1;

    logic running;

    always_ff @(posedge clk) begin
        if (rst) begin
            timebase <= '0;
        end else if (enable && tick) begin
            timebase <= timebase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed <= '0;
            running <= 1'b0;
            stale   <= 1'b0;
        end else if (enable) begin
            if (rise) begin
                elapsed <= '0;
                running <= 1'b1;
                stale   <= 1'b0;
            end else if (running && tick && elapsed != MAXV) begin
                elapsed <= elapsed + 1'b1;
                if (elapsed == NEAR)
                    stale <= 1'b1;
            end
        end
    end

    AST_TB_STEP: assert property (@(posedge clk) disable iff (rst) (enable && tick) |=> timebase == $past(timebase) + 1'b1); // R2
    AST_TB_HOLD: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(timebase)); // R2
    AST_EL_CLEAR: assert property (@(posedge clk) disable iff (rst) (enable && rise) |=> elapsed == '0); // R3
    AST_EL_SAT: assert property (@(posedge clk) disable iff (rst) (elapsed == MAXV && !rise) |=> elapsed == MAXV); // R6
    AST_STALE_MAX: assert property (@(posedge clk) disable iff (rst) stale |-> elapsed == MAXV); // R6
    AST_FROZEN: assert property (@(posedge clk) disable iff (rst) !enable |=> ($stable(elapsed) && $stable(timebase))); // R11

endmodule

// File: rtl/pps_snapshot.sv
module pps_snapshot #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snap_req,
    input  logic             level_in,
    input  logic [CNT_W-1:0] timebase_in,
    input  logic [CNT_W-1:0] elapsed_in,
    input  logic             stale_in,
    output logic             snap_level,
    output logic             snap_new_edge,
    output logic [CNT_W-1:0] snap_timebase,
    output logic [CNT_W-1:0] snap_elapsed,
    output logic             snap_stale
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_level    <= 1'b0;
            snap_new_edge <= 1'b0;
            snap_timebase <= '0;
            snap_elapsed  <= '0;
            snap_stale    <= 1'b0;
        end else if (snap_req) begin
            snap_level    <= level_in;
            snap_new_edge <= level_in & ~snap_level;
            snap_timebase <= timebase_in;
            snap_elapsed  <= elapsed_in;
            snap_stale    <= stale_in;
        end
    end

    AST_SNAP_TB: assert property (@(posedge clk) disable iff (rst) snap_req |=> snap_timebase == $past(timebase_in)); // R7
    AST_SNAP_EL: assert property (@(posedge clk) disable iff (rst) snap_req |=> snap_elapsed == $past(elapsed_in)); // R7
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst) !snap_req |=> ($stable(snap_timebase) && $stable(snap_elapsed) && $stable(snap_level))); // R7
    AST_NEW_EDGE: assert property (@(posedge clk) disable iff (rst) snap_new_edge |-> snap_level); // R9

endmodule

// File: rtl/pps_stamp_top.sv
module pps_stamp_top
    import pps_stamp_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int DIV   = DEF_DIV
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             pps_in,
    input  logic             echo_en,
    input  logic             echo_invert,
    input  logic             snap_req,
    output logic             snap_level,
    output logic             snap_new_edge,
    output logic [CNT_W-1:0] snap_timebase,
    output logic [CNT_W-1:0] snap_elapsed,
    output logic             snap_stale,
    output logic [CNT_W-1:0] stamp,
    output logic             echo_out
);
    logic             level, rise, tick, stale;
    logic [CNT_W-1:0] timebase, elapsed;
    echo_mode_e       mode;

    pps_sync_edge u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (pps_in),
        .level (level),
        .rise  (rise)
    );

    pps_prescaler #(.DIV(DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .tick   (tick)
    );

    pps_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .tick     (tick),
        .rise     (rise),
        .timebase (timebase),
        .elapsed  (elapsed),
        .stale    (stale)
    );

    pps_snapshot #(.CNT_W(CNT_W)) u_snap (
        .clk           (clk),
        .rst           (rst),
        .snap_req      (snap_req),
        .level_in      (level),
        .timebase_in   (timebase),
        .elapsed_in    (elapsed),
        .stale_in      (stale),
        .snap_level    (snap_level),
        .snap_new_edge (snap_new_edge),
        .snap_timebase (snap_timebase),
        .snap_elapsed  (snap_elapsed),
        .snap_stale    (snap_stale)
    );

    assign stamp    = snap_timebase - snap_elapsed;
    assign mode     = echo_mode(echo_en, echo_invert);
    assign echo_out = echo_drive(mode, level);

    AST_ECHO_OFF: assert property (@(posedge clk) disable iff (rst) !echo_en |-> !echo_out); // R10
    AST_RESET_ZERO: assert property (@(posedge clk) $past(rst) |-> (snap_timebase == '0 && snap_elapsed == '0 && !snap_level)); // R1

endmodule

// File: tb/pps_stamp_top_bench.sv
module pps_stamp_top_bench;
    localparam int W = 8;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst, enable, pps_in, echo_en, echo_invert, snap_req;
    logic snap_level, snap_new_edge, snap_stale, echo_out;
    logic [W-1:0] snap_timebase, snap_elapsed, stamp;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pps_stamp_top #(.CNT_W(W), .DIV(D)) u_pps_stamp_top (
        .clk(clk), .rst(rst), .enable(enable), .pps_in(pps_in),
        .echo_en(echo_en), .echo_invert(echo_invert), .snap_req(snap_req),
        .snap_level(snap_level), .snap_new_edge(snap_new_edge),
        .snap_timebase(snap_timebase), .snap_elapsed(snap_elapsed),
        .snap_stale(snap_stale), .stamp(stamp), .echo_out(echo_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic snap();
        snap_req = 1'b1;
        @(negedge clk);
        snap_req = 1'b0;
    endtask

    logic [W-1:0] tb_a, tb_b, el_a, st1;

    task automatic t_reset();
        chk(snap_timebase == 0 && snap_elapsed == 0, "R1", snap_timebase, 0);
        chk(!snap_level && !snap_new_edge && !snap_stale && !echo_out, "R1", echo_out, 0);
        chk(stamp == 0, "R1", stamp, 0);
    endtask

    task automatic t_timebase();
        enable = 1'b1;
        snap();
        tb_a = snap_timebase;
        chk(snap_elapsed == 0, "R3 idle before first edge", snap_elapsed, 0);
        cyc(10);
        chk(snap_timebase == tb_a, "R7 hold", snap_timebase, tb_a);
        cyc(29);
        snap();
        chk(W'(snap_timebase - tb_a) == 10, "R2", W'(snap_timebase - tb_a), 10);
    endtask

    task automatic t_edge();
        echo_en = 1'b1; echo_invert = 1'b0;
        pps_in = 1'b1;
        snap();
        tb_a = snap_timebase;
        chk(!snap_level, "R4 level not yet through", snap_level, 0);
        chk(!echo_out, "R4 echo after one edge", echo_out, 0);
        @(negedge clk);
        chk(echo_out, "R4 echo after two edges", echo_out, 1);
        cyc(2);
        snap();
        chk(snap_level && snap_new_edge, "R9 new edge", snap_new_edge, 1);
        chk(snap_elapsed <= 2, "R3 cleared", snap_elapsed, 0);
        chk(stamp == tb_a || stamp == W'(tb_a + 1), "R8 near edge time", stamp, tb_a);
        st1 = stamp; el_a = snap_elapsed;
        cyc(19);
        snap();
        chk(W'(snap_elapsed - el_a) == 5, "R3 rate", W'(snap_elapsed - el_a), 5);
        chk(stamp == st1, "R8 constant", stamp, st1);
        chk(!snap_new_edge, "R9 second high snapshot", snap_new_edge, 0);
    endtask

    task automatic t_fall();
        el_a = snap_elapsed;
        pps_in = 1'b0;
        cyc(5);
        snap();
        chk(!snap_level && !snap_new_edge, "R9 falling", snap_new_edge, 0);
        chk(snap_elapsed > el_a, "R5 not cleared", snap_elapsed, el_a + 1);
        chk(stamp == st1, "R5 stamp kept", stamp, st1);
    endtask

    task automatic t_echo();
        echo_invert = 1'b1;
        #1;
        chk(echo_out, "R10 inverted", echo_out, 1);
        echo_en = 1'b0;
        #1;
        chk(!echo_out, "R10 off", echo_out, 0);
        @(negedge clk);
    endtask

    task automatic t_reedge();
        pps_in = 1'b1;
        cyc(6);
        snap();
        chk(snap_elapsed <= 2 && snap_new_edge, "R3 second edge", snap_elapsed, 0);
        chk(!snap_stale, "R6 fresh", snap_stale, 0);
    endtask

    task automatic t_saturate();
        cyc(1100);
        snap();
        tb_a = snap_timebase;
        chk(snap_elapsed == 8'hFF, "R6 saturate", snap_elapsed, 255);
        chk(snap_stale, "R6 stale", snap_stale, 1);
        cyc(39);
        snap();
        chk(snap_elapsed == 8'hFF, "R6 stays", snap_elapsed, 255);
        chk(W'(snap_timebase - tb_a) == 10, "R2 wrap", W'(snap_timebase - tb_a), 10);
        pps_in = 1'b0; cyc(4);
        pps_in = 1'b1; cyc(6);
        snap();
        chk(!snap_stale && snap_elapsed <= 2, "R6 cleared by edge", snap_stale, 0);
    endtask

    task automatic t_enable();
        enable = 1'b0;
        @(negedge clk);
        snap();
        tb_a = snap_timebase; el_a = snap_elapsed;
        pps_in = 1'b0; cyc(5);
        pps_in = 1'b1; cyc(10);
        snap();
        tb_b = snap_timebase;
        chk(tb_b == tb_a, "R11 time base frozen", tb_b, tb_a);
        chk(snap_elapsed == el_a, "R11 edge ignored", snap_elapsed, el_a);
        enable = 1'b1;
    endtask

    initial begin
        rst = 1'b1; enable = 1'b0; pps_in = 1'b0;
        echo_en = 1'b0; echo_invert = 1'b0; snap_req = 1'b0;
        cyc(4);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_timebase();
        t_edge();
        t_fall();
        t_echo();
        t_reedge();
        t_saturate();
        t_enable();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int n = 0; n < 20000; n++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule